// File: doc/BRIEF.md
# Dual-Mode VGA Scan Doubler

This block turns a 50 Hz home-computer video stream into a 100 Hz VGA picture. Incoming pixels are written into an external single-port frame-buffer RAM in raster order. Reads from that RAM build a VGA raster at twice the line rate and twice the frame rate. Because the source fills the buffer once per source frame and the display sweeps it twice, every stored frame is shown on two consecutive output frames.

The output raster has a fixed active area of `ACT_W` x `ACT_H` pixels. The mode is chosen by a select input. In hi-res mode every active pixel comes from the buffer. In standard mode, the buffer supplies only a centred window that is `2*BORDER` narrower and `2*BORDER` shorter than the active area, and the frame around that window shows the border colour input. Each pixel is 4 bits wide, carrying red, green, blue and intensity.

The RAM is shared between reads and writes through a fixed two-cycle pixel period. The first cycle is the write slot and the second is the read slot, so a source pixel never delays the display.

Top module: `vga_scan_doubler`

## Requirements
- R1: While reset is high, and in the cycle after it, `rgbi_o` is 0, `hsync_o` and `vsync_o` are 1, and both RAM enables are 0. The display mode after reset is standard.
- R2: The raster has `ACT_W+H_FP+H_SW+H_BP` pixels per line and `ACT_H+V_FP+V_SW+V_BP` lines, each pixel lasting two clocks. `hsync_o` is low for the `H_SW` pixels starting at column `ACT_W+H_FP`. `vsync_o` is low for the `V_SW` lines starting at line `ACT_H+V_FP`. Both syncs are active low.
- R3: `rgbi_o` is 0 for every pixel outside the active area.
- R4: In hi-res mode (`mode_i`=1), every active pixel shows the buffer word at the next read address. Read addresses run 0, 1, 2, ... in raster order within each frame.
- R5: In standard mode (`mode_i`=0), the active pixels in columns `BORDER`..`ACT_W-BORDER-1` of lines `BORDER`..`ACT_H-BORDER-1` show buffer words at consecutive addresses from 0. All other active pixels show `border_i`, sampled in the first clock of that pixel's period.
- R6: `mode_i` is sampled only in the first clock of column 0 of line `ACT_H` (the start of vertical blanking). A change at any other time takes effect on the next output frame.
- R7: A source pixel with `src_sof_i`=1 is written to address 0. Each following source pixel is written to the next address. Every accepted pixel is written exactly once. `src_valid_i` may be high on at most one of any two consecutive clocks.
- R8: `fb_rd_en_o` is high only in the second clock of a pixel period, and `fb_wr_en_o` only in the first. The two are never high together, and `fb_addr_o` carries the address of whichever enable is high.
- R9: The read address restarts at 0 every output frame. With the buffer, mode and border unchanged, two consecutive output frames are identical.
- R10: A pixel whose period starts at clock c appears on the outputs from clock c+3 and holds for two clocks. The syncs are delayed by the same amount.
- R11: `fb_rd_data_i` is taken one clock after the clock in which `fb_rd_en_o` is high, which suits a RAM with a registered read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two clocks per output pixel |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = bordered standard layout, 1 = full-screen hi-res |
| border_i | input | 4 | Border colour, RGBI |
| src_valid_i | input | 1 | Source pixel present |
| src_sof_i | input | 1 | Marks the first pixel of a source frame |
| src_pix_i | input | 4 | Source pixel, RGBI |
| fb_addr_o | output | ADDR_W | Frame-buffer address |
| fb_rd_en_o | output | 1 | Frame-buffer read strobe |
| fb_wr_en_o | output | 1 | Frame-buffer write strobe |
| fb_wr_data_o | output | 4 | Frame-buffer write data |
| fb_rd_data_i | input | 4 | Frame-buffer read data, one clock after the read strobe |
| rgbi_o | output | 4 | VGA pixel, RGBI |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |

## Verification
The assertions check the rules that hold on every clock:
- the RAM slot discipline and the exclusion between reads and writes;
- read addresses staying inside the buffer;
- black output whenever a sync is low;
- output pixels holding for two clocks;
- the mode latch changing only at the start of vertical blanking;
- the spacing of source pixels.

Only the bench's scenarios can show the rest. A behavioural raster model, compared on every clock, checks the placement of pictures and borders in both layouts and the three-clock output latency. The same scenarios show the deferred mode switch, a frame restart in the middle of a source frame, and two identical output frames per stored frame.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int PIX_W = 4;

  typedef enum logic {
    MODE_STD   = 1'b0,
    MODE_HIRES = 1'b1
  } disp_mode_e;

  typedef enum logic [1:0] {
    PK_BLANK   = 2'd0,
    PK_BORDER  = 2'd1,
    PK_PICTURE = 2'd2
  } pix_kind_e;

  typedef struct packed {
    pix_kind_e        kind;
    logic [PIX_W-1:0] border;
    logic             hs_n;
    logic             vs_n;
  } pix_tag_t;
endpackage

// File: rtl/vsd_timing.sv
module vsd_timing #(
  parameter int ACT_W = 320,
  parameter int ACT_H = 256,
  parameter int H_FP  = 16,
  parameter int H_SW  = 48,
  parameter int H_BP  = 32,
  parameter int V_FP  = 3,
  parameter int V_SW  = 4,
  parameter int V_BP  = 17,
  parameter int HW    = 9,
  parameter int VW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  output logic          slot_o,
  output logic [HW-1:0] hpos_o,
  output logic [VW-1:0] vpos_o,
  output logic          act_o,
  output logic          hs_n_o,
  output logic          vs_n_o,
  output logic          vblank_start_o
);
  localparam int H_TOT  = ACT_W + H_FP + H_SW + H_BP;
  localparam int V_TOT  = ACT_H + V_FP + V_SW + V_BP;
  localparam int HS_BEG = ACT_W + H_FP;
  localparam int HS_END = HS_BEG + H_SW;
  localparam int VS_BEG = ACT_H + V_FP;
  localparam int VS_END = VS_BEG + V_SW;

  logic          slot_q;
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  // Pixel period: slot 0 then slot 1; position advances after slot 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= 1'b0;
      h_q    <= '0;
      v_q    <= '0;
    end else begin
      slot_q <= ~slot_q;
      if (slot_q) begin
        if (h_q == HW'(H_TOT - 1)) begin
          h_q <= '0;
          if (v_q == VW'(V_TOT - 1)) v_q <= '0;
          else                       v_q <= v_q + 1'b1;
        end else begin
          h_q <= h_q + 1'b1;
        end
      end
    end
  end

  assign slot_o         = slot_q;
  assign hpos_o         = h_q;
  assign vpos_o         = v_q;
  assign act_o          = (h_q < HW'(ACT_W)) && (v_q < VW'(ACT_H));
  assign vblank_start_o = (h_q == '0) && (v_q == VW'(ACT_H));

  generate
    if (H_SW == 0) begin : g_no_hs
      assign hs_n_o = 1'b1;
    end else begin : g_hs
      assign hs_n_o = !((h_q >= HW'(HS_BEG)) && (h_q < HW'(HS_END)));
    end
    if (V_SW == 0) begin : g_no_vs
      assign vs_n_o = 1'b1;
    end else begin : g_vs
      assign vs_n_o = !((v_q >= VW'(VS_BEG)) && (v_q < VW'(VS_END)));
    end
  endgenerate
endmodule

// File: rtl/vsd_fb_port.sv
module vsd_fb_port
  import vsd_pkg::*;
#(
  parameter int ACT_W  = 320,
  parameter int ACT_H  = 256,
  parameter int BORDER = 32,
  parameter int HW     = 9,
  parameter int VW     = 9,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_i,
  input  logic [HW-1:0]     hpos_i,
  input  logic [VW-1:0]     vpos_i,
  input  logic              act_i,
  input  logic              hs_n_i,
  input  logic              vs_n_i,
  input  logic              vblank_start_i,
  input  logic              mode_i,
  input  logic [PIX_W-1:0]  border_i,
  input  logic              src_valid_i,
  input  logic              src_sof_i,
  input  logic [PIX_W-1:0]  src_pix_i,
  output logic [ADDR_W-1:0] fb_addr_o,
  output logic              fb_rd_en_o,
  output logic              fb_wr_en_o,
  output logic [PIX_W-1:0]  fb_wr_data_o,
  output pix_tag_t          tag_o,
  output disp_mode_e        mode_o
);
  localparam int WIN_X1 = ACT_W - BORDER;
  localparam int WIN_Y1 = ACT_H - BORDER;

  disp_mode_e        mode_q;
  logic [ADDR_W-1:0] rd_ptr_q;
  logic [ADDR_W-1:0] wr_ptr_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [PIX_W-1:0]  pend_data_q;
  logic              in_win;
  logic              in_pic;
  logic [ADDR_W-1:0] src_base;
  pix_kind_e         kind;

  generate
    if (BORDER == 0) begin : g_nowin
      assign in_win = 1'b1;
    end else begin : g_win
      assign in_win = (hpos_i >= HW'(BORDER)) && (hpos_i < HW'(WIN_X1)) &&
                      (vpos_i >= VW'(BORDER)) && (vpos_i < VW'(WIN_Y1));
    end
  endgenerate

  assign in_pic   = act_i && ((mode_q == MODE_HIRES) || in_win);
  assign src_base = src_sof_i ? '0 : wr_ptr_q;

  always_comb begin
    if (in_pic)     kind = PK_PICTURE;
    else if (act_i) kind = PK_BORDER;
    else            kind = PK_BLANK;
  end

  // Source side: one-deep holding register, drained in the write slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      wr_ptr_q    <= '0;
    end else begin
      pend_q <= src_valid_i | (pend_q & ~slot_i);
      if (src_valid_i) begin
        pend_addr_q <= src_base;
        pend_data_q <= src_pix_i;
        wr_ptr_q    <= src_base + 1'b1;
      end
    end
  end

  // RAM port: the read is issued in slot 1 and the write in slot 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_STD;
      rd_ptr_q     <= '0;
      fb_addr_o    <= '0;
      fb_rd_en_o   <= 1'b0;
      fb_wr_en_o   <= 1'b0;
      fb_wr_data_o <= '0;
      tag_o        <= '{kind: PK_BLANK, border: '0, hs_n: 1'b1, vs_n: 1'b1};
    end else if (!slot_i) begin
      fb_wr_en_o <= 1'b0;
      fb_rd_en_o <= in_pic;
      fb_addr_o  <= in_pic ? rd_ptr_q : '0;
      tag_o      <= '{kind: kind, border: border_i, hs_n: hs_n_i, vs_n: vs_n_i};
      if (vblank_start_i) begin
        mode_q   <= disp_mode_e'(mode_i);
        rd_ptr_q <= '0;
      end else if (in_pic) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
    end else begin
      fb_rd_en_o   <= 1'b0;
      fb_wr_en_o   <= pend_q;
      fb_addr_o    <= pend_q ? pend_addr_q : '0;
      fb_wr_data_o <= pend_data_q;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/vsd_out.sv
module vsd_out
  import vsd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_i,
  input  pix_tag_t         tag_i,
  input  logic [PIX_W-1:0] rd_data_i,
  output logic [PIX_W-1:0] rgbi_o,
  output logic             hsync_o,
  output logic             vsync_o
);
  // Loaded at the end of the slot 0 that follows the read slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      rgbi_o  <= '0;
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
    end else if (!slot_i) begin
      hsync_o <= tag_i.hs_n;
      vsync_o <= tag_i.vs_n;
      unique case (tag_i.kind)
        PK_PICTURE: rgbi_o <= rd_data_i;
        PK_BORDER:  rgbi_o <= tag_i.border;
        default:    rgbi_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vga_scan_doubler.sv
module vga_scan_doubler
  import vsd_pkg::*;
#(
  parameter int ACT_W   = 320,
  parameter int ACT_H   = 256,
  parameter int BORDER  = 32,
  parameter int H_FP    = 16,
  parameter int H_SW    = 48,
  parameter int H_BP    = 32,
  parameter int V_FP    = 3,
  parameter int V_SW    = 4,
  parameter int V_BP    = 17,
  localparam int PIX_CNT = ACT_W * ACT_H,
  localparam int ADDR_W  = $clog2(PIX_CNT),
  localparam int HW      = $clog2(ACT_W + H_FP + H_SW + H_BP),
  localparam int VW      = $clog2(ACT_H + V_FP + V_SW + V_BP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic [3:0]        border_i,
  input  logic              src_valid_i,
  input  logic              src_sof_i,
  input  logic [3:0]        src_pix_i,
  output logic [ADDR_W-1:0] fb_addr_o,
  output logic              fb_rd_en_o,
  output logic              fb_wr_en_o,
  output logic [3:0]        fb_wr_data_o,
  input  logic [3:0]        fb_rd_data_i,
  output logic [3:0]        rgbi_o,
  output logic              hsync_o,
  output logic              vsync_o
);
  logic          slot;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic          act;
  logic          hs_n;
  logic          vs_n;
  logic          vblank_start;
  pix_tag_t      tag;
  disp_mode_e    mode_q;

  vsd_timing #(
    .ACT_W(ACT_W), .ACT_H(ACT_H),
    .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk(clk), .rst(rst), .slot_o(slot), .hpos_o(hpos), .vpos_o(vpos),
    .act_o(act), .hs_n_o(hs_n), .vs_n_o(vs_n), .vblank_start_o(vblank_start)
  );

  vsd_fb_port #(
    .ACT_W(ACT_W), .ACT_H(ACT_H), .BORDER(BORDER),
    .HW(HW), .VW(VW), .ADDR_W(ADDR_W)
  ) u_port (
    .clk(clk), .rst(rst), .slot_i(slot), .hpos_i(hpos), .vpos_i(vpos),
    .act_i(act), .hs_n_i(hs_n), .vs_n_i(vs_n), .vblank_start_i(vblank_start),
    .mode_i(mode_i), .border_i(border_i),
    .src_valid_i(src_valid_i), .src_sof_i(src_sof_i), .src_pix_i(src_pix_i),
    .fb_addr_o(fb_addr_o), .fb_rd_en_o(fb_rd_en_o), .fb_wr_en_o(fb_wr_en_o),
    .fb_wr_data_o(fb_wr_data_o), .tag_o(tag), .mode_o(mode_q)
  );

  vsd_out u_out (
    .clk(clk), .rst(rst), .slot_i(slot), .tag_i(tag), .rd_data_i(fb_rd_data_i),
    .rgbi_o(rgbi_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );
endmodule

// File: rtl/vga_scan_doubler_chk.sv
module vga_scan_doubler_chk #(
  parameter int ADDR_W  = 17,
  parameter int PIX_CNT = 81920
) (
  input logic              clk,
  input logic              rst,
  input logic              src_valid_i,
  input logic              fb_rd_en_o,
  input logic              fb_wr_en_o,
  input logic [ADDR_W-1:0] fb_addr_o,
  input logic [3:0]        rgbi_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              slot,
  input logic              vblank_start,
  input logic              mode_q
);
  a_r8_no_collision: assert property (@(posedge clk) disable iff (rst)
    !(fb_rd_en_o && fb_wr_en_o));

  a_r8_read_slot: assert property (@(posedge clk) disable iff (rst)
    fb_rd_en_o |-> slot);

  a_r8_write_slot: assert property (@(posedge clk) disable iff (rst)
    fb_wr_en_o |-> !slot);

  a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
    fb_rd_en_o |-> ({1'b0, fb_addr_o} < (ADDR_W + 1)'(PIX_CNT)));

  a_r3_black_in_sync: assert property (@(posedge clk) disable iff (rst)
    (!hsync_o || !vsync_o) |-> (rgbi_o == 4'd0));

  a_r10_pixel_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rgbi_o) |=> $stable(rgbi_o));

  a_r6_mode_at_vblank: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> $past(vblank_start && !slot));

  a_r7_src_spacing: assert property (@(posedge clk) disable iff (rst)
    src_valid_i |=> !src_valid_i);
endmodule

bind vga_scan_doubler vga_scan_doubler_chk #(
  .ADDR_W(ADDR_W), .PIX_CNT(PIX_CNT)
) u_chk (
  .clk(clk), .rst(rst), .src_valid_i(src_valid_i),
  .fb_rd_en_o(fb_rd_en_o), .fb_wr_en_o(fb_wr_en_o), .fb_addr_o(fb_addr_o),
  .rgbi_o(rgbi_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .slot(slot), .vblank_start(vblank_start), .mode_q(mode_q)
);

// File: tb/vga_scan_doubler_bench.sv
module vga_scan_doubler_bench;
  localparam int AW = 12, AH = 8, BD = 2;
  localparam int HFP = 1, HSW = 2, HBP = 1, VFP = 1, VSW = 1, VBP = 1;
  localparam int HT = AW + HFP + HSW + HBP;
  localparam int VT = AH + VFP + VSW + VBP;
  localparam int FRAME = HT * VT * 2;
  localparam int NPIX = AW * AH;
  localparam int ADDR_W = $clog2(NPIX);

  logic clk = 1'b0, rst = 1'b1, mode = 1'b1;
  logic src_valid = 1'b0, src_sof = 1'b0;
  logic [3:0] border = 4'd0, src_pix = 4'd0, fb_wr_data, fb_rd_data = 4'd0, rgbi;
  logic [ADDR_W-1:0] fb_addr;
  logic fb_rd_en, fb_wr_en, hsync, vsync;

  always #2 clk = ~clk;

  vga_scan_doubler #(
    .ACT_W(AW), .ACT_H(AH), .BORDER(BD),
    .H_FP(HFP), .H_SW(HSW), .H_BP(HBP), .V_FP(VFP), .V_SW(VSW), .V_BP(VBP)
  ) u_vga_scan_doubler (
    .clk(clk), .rst(rst), .mode_i(mode), .border_i(border),
    .src_valid_i(src_valid), .src_sof_i(src_sof), .src_pix_i(src_pix),
    .fb_addr_o(fb_addr), .fb_rd_en_o(fb_rd_en), .fb_wr_en_o(fb_wr_en),
    .fb_wr_data_o(fb_wr_data), .fb_rd_data_i(fb_rd_data),
    .rgbi_o(rgbi), .hsync_o(hsync), .vsync_o(vsync)
  );

  // Frame-buffer RAM with registered read.
  logic [3:0] mem [0:(1<<ADDR_W)-1];
  initial for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 4'd0;
  always @(posedge clk) begin
    if (fb_wr_en) mem[fb_addr] <= fb_wr_data;
    if (fb_rd_en) fb_rd_data <= mem[fb_addr];
  end

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, k);
    end
  endtask

  // Reference raster model.
  typedef struct { int rgbi; int hs; int vs; string req; bit skip; } exp_t;
  exp_t q[$];
  exp_t cur, ent;
  int k = 0, ref_ptr = 0, ref_mode = 0, waddr = 0, sent = 0, wrs = 0;
  int pp, hh, vv;
  int ref_img [NPIX];
  int wtime [NPIX];
  int sig = 0;
  int sigs [64];

  initial for (int i = 0; i < NPIX; i++) begin ref_img[i] = 0; wtime[i] = -1000; end

  always @(posedge clk) begin
    if (rst) begin
      k = 0; ref_ptr = 0; ref_mode = 0; q.delete();
      cur.rgbi = 0; cur.hs = 1; cur.vs = 1; cur.req = "R1"; cur.skip = 0;
    end else begin
      if (k % 2 == 0) begin
        pp = k / 2; hh = pp % HT; vv = (pp / HT) % VT;
        if (q.size() > 0) cur = q.pop_front();
        if (hh == 0 && vv == AH) begin ref_mode = mode; ref_ptr = 0; end
        ent.hs = (hh >= AW + HFP && hh < AW + HFP + HSW) ? 0 : 1;
        ent.vs = (vv >= AH + VFP && vv < AH + VFP + VSW) ? 0 : 1;
        ent.skip = 0;
        if (hh < AW && vv < AH) begin
          if (ref_mode == 1 || (hh >= BD && hh < AW - BD && vv >= BD && vv < AH - BD)) begin
            ent.rgbi = ref_img[ref_ptr];
            ent.skip = (k - wtime[ref_ptr]) < 10;
            ent.req = (ref_mode == 1) ? "R4 R10 R11" : "R5 R10 R11";
            ref_ptr++;
          end else begin
            ent.rgbi = border; ent.req = "R5";
          end
          if (ref_mode != mode) ent.req = {ent.req, " R6"};
        end else begin
          ent.rgbi = 0; ent.req = "R3";
        end
        q.push_back(ent);
      end
      k++;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (!cur.skip) chk(rgbi == cur.rgbi, cur.req, rgbi, cur.rgbi);
      chk(hsync == cur.hs, "R2 hsync", hsync, cur.hs);
      chk(vsync == cur.vs, "R2 vsync", vsync, cur.vs);
      if (fb_rd_en) chk(k % 2 == 1, "R8 read slot", k % 2, 1);
      if (fb_wr_en) begin wrs++; chk(k % 2 == 0, "R8 write slot", k % 2, 0); end
      if (k >= 3) begin
        if ((k - 3) % FRAME == 0) sig = 0;
        sig = sig * 31 + int'(rgbi) + 1;
        if ((k - 3) % FRAME == FRAME - 1 && (k - 3) / FRAME < 64) sigs[(k - 3) / FRAME] = sig;
      end
    end
  end

  task automatic send(input int n, input bit sof, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_valid = 1'b1;
      src_sof = sof && (i == 0);
      src_pix = 4'((seed + i * 5) % 16);
      if (src_sof) waddr = 0;
      ref_img[waddr] = (seed + i * 5) % 16;
      wtime[waddr] = k;
      waddr++; sent++;
      @(negedge clk);
      src_valid = 1'b0; src_sof = 1'b0;
    end
  endtask

  task automatic wait_k(input int kk);
    while (k < kk) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(rgbi == 4'd0, "R1 rgbi", rgbi, 0);
    chk(hsync == 1'b1, "R1 hsync", hsync, 1);
    chk(vsync == 1'b1, "R1 vsync", vsync, 1);
    chk(!fb_rd_en && !fb_wr_en, "R1 enables", fb_rd_en | fb_wr_en, 0);
    rst = 1'b0;
    // mode_i=1 held across reset: the first frame must still be standard (R1, R6).
    wait_k(40);
    mode = 1'b0; border = 4'hA;
    send(NPIX, 1'b1, 1);                       // R7 full frame
    wait_k(3 * FRAME + 10);
    chk(sigs[1] == sigs[2], "R9 std repeat", sigs[2], sigs[1]);
    wait_k(3 * FRAME + 100);
    mode = 1'b1;                               // R6 mid-frame change
    wait_k(6 * FRAME + 10);
    chk(sigs[4] == sigs[5], "R9 hires repeat", sigs[5], sigs[4]);
    chk(sigs[4] != sigs[1], "R4 hires differs", sigs[4], sigs[1]);
    send(30, 1'b1, 7);                         // R7 partial frame
    send(NPIX, 1'b1, 3);                       // R7 restart at address 0
    wait_k(8 * FRAME + 50);
    border = 4'h5; mode = 1'b0;
    wait_k(10 * FRAME + 50);
    send(40, 1'b1, 11);
    wait_k(12 * FRAME + 10);
    chk(wrs == sent, "R7 write count", wrs, sent);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", k, 12 * FRAME);
      summary();
      $finish;
    end
  end
endmodule